// File: doc/BRIEF.md
# Sideband Message Serializer

This block takes one decoded link-layer message at a time as a parallel record and replays it on a narrow sideband. The sideband consists of a strobe, a 5-bit message code and an 8-bit byte lane. The record holds the message code, the requester bus number, the device/function number, a 32-bit payload word, a 16-bit vendor identifier and a flag that says whether the payload carries data. While the strobe is high, the block presents one parameter byte per cycle. How many bytes it sends, and in what order, depends on the message code and, for vendor messages, on the data flag.

The input side uses a ready/valid handshake and holds at most one message. After the last byte of a message, the block spends one gap cycle with the strobe low before it accepts the next record. Codes that name no message are taken off the input and never appear on the sideband. For latency-tolerance messages, the payload word carries both latencies: snoop latency in bits [15:0] and no-snoop latency in bits [31:16].

Top module: `msg_sideband_ser`

## Requirements
- R1: A synchronous active-high reset, sampled at a rising edge, leaves the block idle from the next cycle: strobe low, code and byte lane zero, input ready high. Any message in flight is abandoned.
- R2: A record is accepted at a rising edge where `in_valid` and `in_ready` are both high. For a legal code, the strobe rises in the cycle after that edge. `in_ready` stays low from that cycle through the gap cycle.
- R3: Codes 0 to 14 and code 18 hold the strobe for exactly 2 cycles: the bus number first, then the device/function number.
- R4: Code 15 holds the strobe for 6 cycles: the two ID bytes, then payload bytes [7:0], [15:8], [23:16] and [31:24] in that order.
- R5: Code 16 holds the strobe for 6 cycles: the two ID bytes, then snoop latency low and high byte (payload [7:0], [15:8]), then no-snoop latency low and high byte (payload [23:16], [31:24]).
- R6: Codes 19 and 20 hold the strobe for 4 cycles when the data flag is 0: the two ID bytes, then vendor ID low byte and high byte. When the flag is 1 they hold it for 8 cycles, with the four payload bytes following, least significant first.
- R7: While the strobe is high, `out_type` equals the accepted code and does not change.
- R8: After the last byte of every message there is exactly one gap cycle with the strobe low and `in_ready` low. `in_ready` returns high in the cycle after the gap.
- R9: Whenever the strobe is low, `out_type` and `out_data` are zero.
- R10: Codes 17 and 21 to 31 are reserved. Such a record is accepted and then dropped: the strobe stays low, and `in_ready` is high again in the next cycle.
- R11: For every code other than 19 and 20, the data flag has no effect on beat count or byte content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input record is present |
| in_ready | output | 1 | Block can take a record this cycle |
| in_type | input | 5 | Message code of the record |
| in_bus | input | 8 | Requester bus number |
| in_devfn | input | 8 | Requester device/function number |
| in_payload | input | 32 | Payload word (latencies for code 16) |
| in_vendor | input | 16 | Vendor identifier |
| in_has_data | input | 1 | Vendor message carries a payload |
| out_valid | output | 1 | Sideband strobe |
| out_type | output | 5 | Message code while strobe is high, else zero |
| out_data | output | 8 | Parameter byte while strobe is high, else zero |

## Verification
Take E as the rising edge that accepts a record. Byte k of the message appears in the k-th cycle after E. The gap cycle follows the last byte, and `in_ready` is high again one cycle after that. A reserved code shows no strobe and has `in_ready` high in the first cycle after E.

The bench keeps a queue of expected per-cycle values. When it sees a handshake, it appends one entry per byte and then a gap entry. On every falling edge it pops exactly one entry and compares the strobe, code, byte and ready against it, so each result is sampled half a period after the edge that produced it. A reset applied in the middle of a message clears the queue, so the bench then expects the idle state from the cycle after the reset edge.

// File: rtl/msgser_pkg.sv
package msgser_pkg;

    localparam int CODE_W    = 5;
    localparam int BYTE_W    = 8;
    localparam int ID_BYTES  = 2;
    localparam int VID_BYTES = 2;
    localparam int PLD_BYTES = 4;
    localparam int MAX_BEATS = ID_BYTES + VID_BYTES + PLD_BYTES;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);

    typedef logic [CODE_W-1:0]           code_t;
    typedef logic [BYTE_W-1:0]           byte_t;
    typedef logic [BEAT_W-1:0]           beat_t;
    typedef logic [PLD_BYTES*BYTE_W-1:0] word_t;
    typedef logic [VID_BYTES*BYTE_W-1:0] vid_t;

    // Message codes seen on the sideband
    typedef enum code_t {
        MC_ERR_CORR   = 5'd0,
        MC_ERR_NONFAT = 5'd1,
        MC_ERR_FATAL  = 5'd2,
        MC_IRQ_A_ON   = 5'd3,
        MC_IRQ_A_OFF  = 5'd4,
        MC_IRQ_B_ON   = 5'd5,
        MC_IRQ_B_OFF  = 5'd6,
        MC_IRQ_C_ON   = 5'd7,
        MC_IRQ_C_OFF  = 5'd8,
        MC_IRQ_D_ON   = 5'd9,
        MC_IRQ_D_OFF  = 5'd10,
        MC_PWR_EVT    = 5'd11,
        MC_PWR_OFFACK = 5'd12,
        MC_PWR_OFFREQ = 5'd13,
        MC_PWR_NAK    = 5'd14,
        MC_SLOT_PWR   = 5'd15,
        MC_LAT_REPORT = 5'd16,
        MC_UNLOCK     = 5'd18,
        MC_VND_T0     = 5'd19,
        MC_VND_T1     = 5'd20
    } msg_code_e;

    // Byte layout class of a message
    typedef enum logic [1:0] {
        FMT_DROP   = 2'd0,
        FMT_ID     = 2'd1,
        FMT_WORD   = 2'd2,
        FMT_VENDOR = 2'd3
    } fmt_e;

    typedef struct packed {
        code_t code;
        byte_t bus;
        byte_t devfn;
        word_t payload;
        vid_t  vid;
    } msg_rec_t;

    function automatic fmt_e fmt_of(code_t c);
        fmt_e f;
        if (c <= code_t'(MC_PWR_NAK) || c == code_t'(MC_UNLOCK))
            f = FMT_ID;
        else if (c == code_t'(MC_SLOT_PWR) || c == code_t'(MC_LAT_REPORT))
            f = FMT_WORD;
        else if (c == code_t'(MC_VND_T0) || c == code_t'(MC_VND_T1))
            f = FMT_VENDOR;
        else
            f = FMT_DROP;
        return f;
    endfunction

    function automatic beat_t beats_of(fmt_e f, logic has_data);
        beat_t n;
        unique case (f)
            FMT_ID:     n = beat_t'(ID_BYTES);
            FMT_WORD:   n = beat_t'(ID_BYTES + PLD_BYTES);
            FMT_VENDOR: n = has_data ? beat_t'(MAX_BEATS)
                                     : beat_t'(ID_BYTES + VID_BYTES);
            default:    n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/msgser_classify.sv
module msgser_classify
    import msgser_pkg::*;
(
    input  code_t code,
    input  logic  has_data,
    output fmt_e  fmt,
    output beat_t nbeats,
    output logic  legal
);
    always_comb begin
        fmt    = fmt_of(code);
        nbeats = beats_of(fmt, has_data);
        legal  = (fmt != FMT_DROP);
    end
endmodule

// File: rtl/msgser_hold.sv
module msgser_hold
    import msgser_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  msg_rec_t rec_d,
    input  fmt_e     fmt_d,
    output msg_rec_t rec_q,
    output fmt_e     fmt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
            fmt_q <= FMT_DROP;
        end else if (load) begin
            rec_q <= rec_d;
            fmt_q <= fmt_d;
        end
    end
endmodule

// File: rtl/msgser_seq.sv
module msgser_seq
    import msgser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  legal,
    input  beat_t nbeats,
    output logic  ready,
    output logic  load,
    output logic  sending,
    output beat_t beat
);
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SEND = 2'd1,
        S_GAP  = 2'd2
    } seq_e;

    seq_e  st;
    beat_t last_q;

    assign ready   = (st == S_IDLE);
    assign load    = ready && in_valid && legal;
    assign sending = (st == S_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            beat   <= '0;
            last_q <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (load) begin
                        st     <= S_SEND;
                        beat   <= '0;
                        last_q <= nbeats - beat_t'(1);
                    end
                end
                S_SEND: begin
                    if (beat == last_q) begin
                        st   <= S_GAP;
                        beat <= '0;
                    end else begin
                        beat <= beat + beat_t'(1);
                    end
                end
                S_GAP:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msgser_beatsel.sv
module msgser_beatsel
    import msgser_pkg::*;
(
    input  fmt_e  fmt,
    input  beat_t beat,
    input  byte_t bus,
    input  byte_t devfn,
    input  word_t payload,
    input  vid_t  vid,
    output byte_t sel_byte
);
    byte_t id_b  [ID_BYTES];
    byte_t vid_b [VID_BYTES];
    byte_t pld_b [PLD_BYTES];

    assign id_b[0] = bus;
    assign id_b[1] = devfn;

    genvar g;
    generate
        for (g = 0; g < VID_BYTES; g++) begin : g_vid
            assign vid_b[g] = vid[g*BYTE_W +: BYTE_W];
        end
        for (g = 0; g < PLD_BYTES; g++) begin : g_pld
            assign pld_b[g] = payload[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        int rel;
        int pidx;
        sel_byte = '0;
        rel      = int'(beat) - ID_BYTES;
        pidx     = (fmt == FMT_VENDOR) ? rel - VID_BYTES : rel;
        for (int i = 0; i < ID_BYTES; i++)
            if (int'(beat) == i) sel_byte = id_b[i];
        if (fmt == FMT_VENDOR)
            for (int i = 0; i < VID_BYTES; i++)
                if (rel == i) sel_byte = vid_b[i];
        if (fmt == FMT_VENDOR || fmt == FMT_WORD)
            for (int i = 0; i < PLD_BYTES; i++)
                if (pidx == i) sel_byte = pld_b[i];
    end
endmodule

// File: rtl/msg_sideband_ser.sv
module msg_sideband_ser
    import msgser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [4:0]  in_type,
    input  logic [7:0]  in_bus,
    input  logic [7:0]  in_devfn,
    input  logic [31:0] in_payload,
    input  logic [15:0] in_vendor,
    input  logic        in_has_data,
    output logic        out_valid,
    output logic [4:0]  out_type,
    output logic [7:0]  out_data
);
    msg_rec_t rec_in, rec_q;
    fmt_e     fmt_in, fmt_q;
    beat_t    nbeats_in, beat;
    logic     legal_in, load, sending;
    byte_t    cur_byte;

    assign rec_in = '{code: in_type, bus: in_bus, devfn: in_devfn,
                      payload: in_payload, vid: in_vendor};

    msgser_classify u_cls (
        .code     (in_type),
        .has_data (in_has_data),
        .fmt      (fmt_in),
        .nbeats   (nbeats_in),
        .legal    (legal_in)
    );

    msgser_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .legal    (legal_in),
        .nbeats   (nbeats_in),
        .ready    (in_ready),
        .load     (load),
        .sending  (sending),
        .beat     (beat)
    );

    msgser_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .rec_d (rec_in),
        .fmt_d (fmt_in),
        .rec_q (rec_q),
        .fmt_q (fmt_q)
    );

    msgser_beatsel u_sel (
        .fmt      (fmt_q),
        .beat     (beat),
        .bus      (rec_q.bus),
        .devfn    (rec_q.devfn),
        .payload  (rec_q.payload),
        .vid      (rec_q.vid),
        .sel_byte (cur_byte)
    );

    assign out_valid = sending;
    assign out_type  = sending ? rec_q.code : '0;
    assign out_data  = sending ? cur_byte   : '0;
endmodule

// File: rtl/msgser_chk.sv
module msgser_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [4:0] in_type,
    input logic       out_valid,
    input logic [4:0] out_type,
    input logic [7:0] out_data
);
    logic [3:0] run_cnt;
    logic [4:0] run_code;
    logic       in_legal;
    logic       len_ok;

    assign in_legal = (in_type != 5'd17) && (in_type <= 5'd20);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            run_code <= '0;
        end else if (out_valid) begin
            run_cnt  <= run_cnt + 4'd1;
            run_code <= out_type;
        end else begin
            run_cnt  <= '0;
        end
    end

    always_comb begin
        if (run_code == 5'd15 || run_code == 5'd16)
            len_ok = (run_cnt == 4'd6);
        else if (run_code == 5'd19 || run_code == 5'd20)
            len_ok = (run_cnt == 4'd4) || (run_cnt == 4'd8);
        else
            len_ok = (run_cnt == 4'd2);
    end

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_type == 5'd0 && out_data == 8'd0));

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(out_type));

    // R10
    no_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_type != 5'd17 && out_type <= 5'd20));

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_legal) |=> (out_valid && out_type == $past(in_type)));

    // R8
    gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> !in_ready);

    // R3 R4 R5 R6
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> len_ok);
endmodule

bind msg_sideband_ser msgser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_type   (in_type),
    .out_valid (out_valid),
    .out_type  (out_type),
    .out_data  (out_data)
);

// File: tb/sim_msg_sideband_ser.sv
module sim_msg_sideband_ser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_type = '0;
    logic [7:0]  in_bus = '0;
    logic [7:0]  in_devfn = '0;
    logic [31:0] in_payload = '0;
    logic [15:0] in_vendor = '0;
    logic        in_has_data = 1'b0;
    logic        out_valid;
    logic [4:0]  out_type;
    logic [7:0]  out_data;

    always #10 clk = ~clk;

    msg_sideband_ser u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_bus(in_bus), .in_devfn(in_devfn),
        .in_payload(in_payload), .in_vendor(in_vendor),
        .in_has_data(in_has_data), .out_valid(out_valid),
        .out_type(out_type), .out_data(out_data)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // expected per-cycle values
    bit    qv[$];
    int    qt[$];
    int    qd[$];
    bit    qr[$];
    string qg[$];

    // stimulus list
    int s_t[$];
    int s_bus[$];
    int s_dev[$];
    int s_pld[$];
    int s_vid[$];
    bit s_hd[$];

    task automatic add_msg(int t, int b, int d, int p, int v, bit hd);
        s_t.push_back(t); s_bus.push_back(b); s_dev.push_back(d);
        s_pld.push_back(p); s_vid.push_back(v); s_hd.push_back(hd);
    endtask

    task automatic push_exp(bit v, int t, int d, bit r, string g);
        qv.push_back(v); qt.push_back(t); qd.push_back(d);
        qr.push_back(r); qg.push_back(g);
    endtask

    task automatic model_accept(int t, int b, int d, int p, int v, bit hd);
        string tg;
        if (t == 17 || t > 20) begin
            push_exp(1'b0, 0, 0, 1'b1, "R10");
            return;
        end
        if (t == 15)               tg = "R4/R7";
        else if (t == 16)          tg = "R5/R7";
        else if (t == 19 || t == 20) tg = "R6/R7";
        else                       tg = "R3/R7";
        if (hd && !(t == 19 || t == 20)) tg = "R11";
        push_exp(1'b1, t, b & 255, 1'b0, "R2");
        push_exp(1'b1, t, d & 255, 1'b0, tg);
        if (t == 19 || t == 20) begin
            push_exp(1'b1, t, v & 255, 1'b0, tg);
            push_exp(1'b1, t, (v >> 8) & 255, 1'b0, tg);
        end
        if (t == 15 || t == 16 || ((t == 19 || t == 20) && hd))
            for (int i = 0; i < 4; i++)
                push_exp(1'b1, t, (p >> (8 * i)) & 255, 1'b0, tg);
        push_exp(1'b0, 0, 0, 1'b0, "R8");
    endtask

    initial begin
        for (int t = 0; t < 32; t++)
            add_msg(t, $urandom, $urandom, $urandom, $urandom, 1'b0);
        add_msg(15, 8'h12, 8'h34, 32'h11223344, 0, 1'b0);
        add_msg(16, 8'hA0, 8'hB1, 32'h87654321, 0, 1'b0);
        add_msg(19, 8'h01, 8'h02, 32'hDEADBEEF, 16'hCAFE, 1'b0);
        add_msg(19, 8'h03, 8'h04, 32'hDEADBEEF, 16'hCAFE, 1'b1);
        add_msg(20, 8'h05, 8'h06, 32'h0BADF00D, 16'h1234, 1'b1);
        add_msg(20, 8'h07, 8'h08, 32'h0BADF00D, 16'h1234, 1'b0);
        add_msg(3, 8'h11, 8'h22, 32'hFFFFFFFF, 0, 1'b1);
        add_msg(15, 8'h33, 8'h44, 32'h55667788, 0, 1'b1);
        add_msg(17, 8'h55, 8'h66, 0, 0, 1'b0);
        add_msg(18, 8'h77, 8'h88, 0, 0, 1'b1);
        for (int i = 0; i < 40; i++)
            add_msg($urandom % 32, $urandom, $urandom, $urandom, $urandom, 1'($urandom));
    end

    initial begin
        int si;
        bit ev, er;
        int et, ed;
        string eg;
        bit nxt_rst;
        si = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (qv.size() > 0) begin
                ev = qv.pop_front(); et = qt.pop_front(); ed = qd.pop_front();
                er = qr.pop_front(); eg = qg.pop_front();
            end else begin
                ev = 1'b0; et = 0; ed = 0; er = 1'b1;
                eg = rst ? "R1" : "R9";
            end
            nchk++;
            if (out_valid !== ev || int'(out_type) != et || int'(out_data) != ed
                || in_ready !== er) begin
                nfail++;
                $display("FAIL %s cycle %0d: valid/type/data/ready = %b/%0d/%h/%b expected %b/%0d/%h/%b",
                         eg, k, out_valid, out_type, out_data, in_ready, ev, et, ed[7:0], er);
            end
            if (si >= s_t.size() && qv.size() == 0 && k > 260) break;
            // R1: reset at start and again mid-stream
            nxt_rst = (k == 0) || (k >= 200 && k < 202);
            if (nxt_rst) begin
                rst = 1'b1;
                in_valid = 1'b0;
                qv.delete(); qt.delete(); qd.delete(); qr.delete(); qg.delete();
            end else begin
                rst = 1'b0;
                if (si < s_t.size() && ($urandom % 4) != 0) begin
                    in_valid    = 1'b1;
                    in_type     = 5'(s_t[si]);
                    in_bus      = 8'(s_bus[si]);
                    in_devfn    = 8'(s_dev[si]);
                    in_payload  = 32'(s_pld[si]);
                    in_vendor   = 16'(s_vid[si]);
                    in_has_data = s_hd[si];
                    if (er) begin
                        model_accept(s_t[si], s_bus[si], s_dev[si], s_pld[si],
                                     s_vid[si], s_hd[si]);
                        si++;
                    end
                end else begin
                    in_valid = 1'b0;
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule